// File: doc/BRIEF.md
# Rounding Accumulator Output Stage

This block is the back end of a filter datapath. Each clock it receives a signed sum of products and either starts a new total with it or adds it to the running total. The total is held in a 32-bit signed accumulator that wraps on overflow. A 16-bit output window is then taken from the total. In fractional format the window is the upper half, and it is rounded by half an output LSB, but only for a total that was started on that cycle. In integer format the window is the lower half and is never rounded.

The windowed value passes through an output register with an active-low load enable. While the output register holds, the accumulator keeps working, so a long accumulation can run with a frozen output and the finished total can be released later. An active-low asynchronous reset, released synchronously inside the block, clears the accumulator and the output register.

Top module: `acc_round_stage`

## Requirements
- R1: While reset is applied `result_o` is 0, and reset clears the accumulator: after release, accumulating a value v onto the total in integer format yields v.
- R2: When `acc_en_i` is 0, the accumulator discards its total and takes the sign-extended `psum_i` as its new value.
- R3: When `acc_en_i` is 1, the sign-extended `psum_i` is added to the accumulator, modulo 2^32, with no rounding.
- R4: A sample taken with `int_fmt_i` = 1 (integer format) presents accumulator bits 15:0, unrounded.
- R5: A sample taken with `int_fmt_i` = 0 (fractional format) presents accumulator bits 31:16.
- R6: A fractional sample taken with `acc_en_i` = 0 is rounded: the output is bits 31:16 of (total + 0x8000), wrapping modulo 2^32 (0x7FFF8000 gives 0x8000).
- R7: A fractional sample taken with `acc_en_i` = 1 is not rounded (total 0x00018000 reached by accumulation gives 0x0001).
- R8: When `out_load_n_i` is 1 at a clock edge, `result_o` keeps its value.
- R9: The accumulator keeps updating while `out_load_n_i` is 1; the first load afterwards shows the full total.
- R10: A sample presented at clock edge k appears on `result_o` at edge k+1, provided `out_load_n_i` is 0 at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| psum_i | input | 32 | Signed sum of products for this cycle |
| acc_en_i | input | 1 | 1 = add to total, 0 = start a new total |
| int_fmt_i | input | 1 | 1 = integer format, 0 = fractional format |
| out_load_n_i | input | 1 | 0 = load output register, 1 = hold it |
| result_o | output | 16 | Registered 16-bit result |

## Verification
A sample enters the accumulator at the edge where it is presented, and its windowed value reaches `result_o` one edge later if the load enable is low at that edge. Reset release takes two further edges through the internal synchronizer. The bench drives inputs at the falling edge, advances a reference model at the rising edge in the same order as the two register stages, and compares `result_o` at the next falling edge. The directed cases on holding, latency and reset check against fixed values that are worked out by hand from this two-edge path.

// File: rtl/acc_round_pkg.sv
package acc_round_pkg;

  typedef enum logic {
    FMT_FRAC = 1'b0,
    FMT_INT  = 1'b1
  } fmt_e;

  // Side information that travels with the accumulator contents
  typedef struct packed {
    logic rnd;   // total was started this cycle in fractional format
    fmt_e fmt;   // format of the sample that produced the total
  } acc_tag_t;

endpackage

// File: rtl/acc_round_reset_sync.sv
module acc_round_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ok = sync_q[STAGES-1];

endmodule

// File: rtl/acc_round_accum.sv
module acc_round_accum
  import acc_round_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_ok,
  input  logic [IN_W-1:0]  psum_i,
  input  logic             acc_en_i,
  input  logic             int_fmt_i,
  output logic [ACC_W-1:0] psum_ext_o,
  output logic [ACC_W-1:0] acc_q,
  output acc_tag_t         tag_q
);

  logic [ACC_W-1:0] acc_d;
  acc_tag_t         tag_d;

  // Sign extension of the incoming product sum to the accumulator width
  generate
    if (ACC_W > IN_W) begin : g_ext
      assign psum_ext_o = {{(ACC_W-IN_W){psum_i[IN_W-1]}}, psum_i};
    end else begin : g_same
      assign psum_ext_o = psum_i[ACC_W-1:0];
    end
  endgenerate

  always_comb begin
    if (acc_en_i) begin
      acc_d = acc_q + psum_ext_o;
    end else begin
      acc_d = psum_ext_o;
    end
    tag_d.fmt = int_fmt_i ? FMT_INT : FMT_FRAC;
    tag_d.rnd = !acc_en_i && !int_fmt_i;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      acc_q <= '0;
      tag_q <= '{rnd: 1'b0, fmt: FMT_FRAC};
    end else begin
      acc_q <= acc_d;
      tag_q <= tag_d;
    end
  end

endmodule

// File: rtl/acc_round_window.sv
module acc_round_window
  import acc_round_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int OUT_W = 16
) (
  input  logic [ACC_W-1:0] acc_i,
  input  acc_tag_t         tag_i,
  output logic [OUT_W-1:0] win_o
);

  localparam int HALF_BIT = ACC_W - OUT_W - 1;
  localparam logic [ACC_W-1:0] HALF_LSB = ACC_W'(1) << HALF_BIT;

  logic [ACC_W-1:0] rounded;

  always_comb begin
    rounded = acc_i + (tag_i.rnd ? HALF_LSB : '0);
    if (tag_i.fmt == FMT_INT) begin
      win_o = acc_i[OUT_W-1:0];
    end else begin
      win_o = rounded[ACC_W-1 -: OUT_W];
    end
  end

endmodule

// File: rtl/acc_round_outreg.sv
module acc_round_outreg #(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ok,
  input  logic             load_n,
  input  logic [OUT_W-1:0] d,
  output logic [OUT_W-1:0] q
);

  logic [OUT_W-1:0] q_d;

  always_comb begin
    q_d = load_n ? q : d;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/acc_round_stage.sv
module acc_round_stage
  import acc_round_pkg::*;
#(
  parameter int IN_W       = 32,
  parameter int ACC_W      = 32,
  parameter int OUT_W      = 16,
  parameter int SYNC_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  psum_i,
  input  logic             acc_en_i,
  input  logic             int_fmt_i,
  input  logic             out_load_n_i,
  output logic [OUT_W-1:0] result_o
);

  logic             rst_ok;
  logic [ACC_W-1:0] psum_ext;
  logic [ACC_W-1:0] acc_q;
  acc_tag_t         tag_q;
  logic [OUT_W-1:0] premux;

  acc_round_reset_sync #(
    .STAGES (SYNC_STAGE)
  ) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  acc_round_accum #(
    .IN_W  (IN_W),
    .ACC_W (ACC_W)
  ) u_acc (
    .clk        (clk),
    .rst_ok     (rst_ok),
    .psum_i     (psum_i),
    .acc_en_i   (acc_en_i),
    .int_fmt_i  (int_fmt_i),
    .psum_ext_o (psum_ext),
    .acc_q      (acc_q),
    .tag_q      (tag_q)
  );

  acc_round_window #(
    .ACC_W (ACC_W),
    .OUT_W (OUT_W)
  ) u_win (
    .acc_i (acc_q),
    .tag_i (tag_q),
    .win_o (premux)
  );

  acc_round_outreg #(
    .OUT_W (OUT_W)
  ) u_out (
    .clk    (clk),
    .rst_ok (rst_ok),
    .load_n (out_load_n_i),
    .d      (premux),
    .q      (result_o)
  );

endmodule

// File: rtl/acc_round_stage_chk.sv
module acc_round_stage_chk #(
  parameter int ACC_W = 32,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_ok,
  input logic             acc_en_i,
  input logic             int_fmt_i,
  input logic             out_load_n_i,
  input logic [ACC_W-1:0] psum_ext,
  input logic [ACC_W-1:0] acc_q,
  input logic             rnd_q,
  input logic [OUT_W-1:0] premux,
  input logic [OUT_W-1:0] result_o
);

  // R1: output is zero while reset is applied
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (result_o == '0));

  // R2: a cleared total equals the previous cycle's sample
  assert_clear_load_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    !$past(acc_en_i) |-> (acc_q == $past(psum_ext)));

  // R3: accumulate adds the sample to the previous total
  assert_accumulate_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(acc_en_i) |-> (acc_q == $past(acc_q) + $past(psum_ext)));

  // R6 / R7: rounding is pending only after a fractional clear
  assert_round_when_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    rnd_q |-> ($past(!acc_en_i) && $past(!int_fmt_i)));

  // R8: held output does not move
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(out_load_n_i) |-> $stable(result_o));

  // R10: a load presents the window of the previous cycle
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    !$past(out_load_n_i) |-> (result_o == $past(premux)));

endmodule

bind acc_round_stage acc_round_stage_chk #(
  .ACC_W (ACC_W),
  .OUT_W (OUT_W)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_ok       (rst_ok),
  .acc_en_i     (acc_en_i),
  .int_fmt_i    (int_fmt_i),
  .out_load_n_i (out_load_n_i),
  .psum_ext     (psum_ext),
  .acc_q        (acc_q),
  .rnd_q        (tag_q.rnd),
  .premux       (premux),
  .result_o     (result_o)
);

// File: tb/test_acc_round_stage.sv
module test_acc_round_stage;

  localparam int CLK_P   = 10;
  localparam int N_RAND  = 3000;
  localparam int WDOG    = 100000;

  logic        clk;
  logic        rst_n;
  logic [31:0] psum;
  logic        acc_en;
  logic        int_fmt;
  logic        load_n;
  logic [15:0] result;

  int n_tests;
  int n_fail;

  // reference model state
  logic [31:0] m_acc;
  logic        m_rnd;
  logic        m_int;
  logic [15:0] m_out;

  acc_round_stage i_acc_round_stage (
    .clk          (clk),
    .rst_n        (rst_n),
    .psum_i       (psum),
    .acc_en_i     (acc_en),
    .int_fmt_i    (int_fmt),
    .out_load_n_i (load_n),
    .result_o     (result)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] window_f(logic [31:0] a, logic rnd, logic isint);
    logic [31:0] r;
    r = a + (rnd ? 32'h0000_8000 : 32'h0);
    if (isint) return a[15:0];
    return r[31:16];
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = '0; m_rnd = 1'b0; m_int = 1'b0; m_out = '0;
  endtask

  // Drive at falling edge, model advances at rising edge, check at next fall
  task automatic step(logic [31:0] p, logic ae, logic fi, logic ln);
    string tag;
    psum = p; acc_en = ae; int_fmt = fi; load_n = ln;
    if (ln)          tag = "R8";
    else if (m_int)  tag = "R4";
    else if (m_rnd)  tag = "R6";
    else             tag = "R5";
    @(posedge clk);
    if (!ln) m_out = window_f(m_acc, m_rnd, m_int);
    m_acc = ae ? m_acc + p : p;
    m_rnd = !ae && !fi;
    m_int = fi;
    @(negedge clk);
    check(tag, result, m_out);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    psum = '0; acc_en = 1'b1; int_fmt = 1'b1; load_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", result, 16'h0000);
    model_reset();
    rst_n = 1'b1;
    repeat (4) step(32'h0, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (WDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none
  end

  initial begin
    n_tests = 0;
    n_fail  = 0;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    psum = '0; acc_en = 1'b0; int_fmt = 1'b0; load_n = 1'b0;
    model_reset();
    @(negedge clk);
    do_reset();

    // R10: latency of one edge after capture
    step(32'h0000_1234, 1'b0, 1'b1, 1'b0);
    step(32'h0000_5678, 1'b0, 1'b1, 1'b0);
    check("R10", result, 16'h1234);
    step(32'h0, 1'b1, 1'b1, 1'b0);
    check("R10", result, 16'h5678);

    // R2 / R4: clear then integer window, negative value sign extends
    step(32'hFFFF_FFFE, 1'b0, 1'b1, 1'b0);
    step(32'h0, 1'b1, 1'b1, 1'b0);
    check("R2", result, 16'hFFFE);

    // R3: accumulation with wrap modulo 2^32
    step(32'hFFFF_FFF0, 1'b0, 1'b1, 1'b0);
    step(32'h0000_0020, 1'b1, 1'b1, 1'b0);
    step(32'h0, 1'b1, 1'b1, 1'b0);
    check("R3", result, 16'h0010);

    // R6: rounding corner values in fractional clear cycles
    step(32'h0001_7FFF, 1'b0, 1'b0, 1'b0);
    step(32'h0001_8000, 1'b0, 1'b0, 1'b0);
    check("R6", result, 16'h0001);
    step(32'h7FFF_8000, 1'b0, 1'b0, 1'b0);
    check("R6", result, 16'h0002);
    step(32'hFFFF_8000, 1'b0, 1'b0, 1'b0);
    check("R6", result, 16'h8000);
    step(32'h0, 1'b0, 1'b1, 1'b0);
    check("R6", result, 16'h0000);

    // R5 / R7: fractional accumulate is not rounded
    step(32'h0001_0000, 1'b0, 1'b0, 1'b0);
    step(32'h0000_8000, 1'b1, 1'b0, 1'b0);
    step(32'h0, 1'b0, 1'b1, 1'b0);
    check("R7", result, 16'h0001);

    // R8 / R9: hold the output while accumulation continues
    step(32'd10, 1'b0, 1'b1, 1'b0);
    step(32'd20, 1'b1, 1'b1, 1'b1);
    check("R8", result, 16'h0000);
    step(32'd30, 1'b1, 1'b1, 1'b1);
    check("R8", result, 16'h0000);
    step(32'd0, 1'b1, 1'b1, 1'b0);
    check("R9", result, 16'd60);

    // Random traffic against the model
    for (int i = 0; i < N_RAND; i++) begin
      logic [31:0] p;
      logic [3:0]  sel;
      sel = 4'($urandom_range(0, 15));
      p = (sel < 4) ? {{16{sel[0]}}, 16'($urandom)} : $urandom;
      step(p, 1'($urandom_range(0, 2) != 0), 1'($urandom), 1'($urandom_range(0, 3) == 0));
    end

    // R1: a reset in mid-stream clears the accumulator
    step(32'h1234_5678, 1'b0, 1'b1, 1'b0);
    do_reset();
    step(32'd7, 1'b1, 1'b1, 1'b0);
    step(32'd0, 1'b1, 1'b1, 1'b0);
    check("R1", result, 16'd7);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule